// File: doc/BRIEF.md
# Display Window Write Sequencer

This block writes a rectangular window of pixel bytes into a display controller. A single `start` pulse captures the first and last column, the first and last row, a source base address and a row stride. The block then emits a fixed preamble: the row-range opcode, first row, last row, the column-range opcode, first column, last column, and finally the memory-write opcode. After the preamble it streams one line of pixel bytes per row, fetched from a byte source through `rd_addr`/`rd_data`.

Every emitted byte carries a command/data tag and an end-of-frame marker, so a downstream serializer can build nine-bit three-wire frames or plain eight-bit frames. The preamble forms one frame, and each pixel line forms its own frame. In four-wire operation a separate data/command pin follows the tag. Each column address covers two bytes, so a line is twice the inclusive column span. A window whose start exceeds its end, or whose line would be longer than the limit, is refused with an error pulse.

Top module: `wire_window_seq`

## Requirements
- R1: After reset `out_valid`, `busy`, `done`, `err` and `dc_pin` are all 0.
- R2: An accepted window first emits seven bytes in this order: OP_ROW (tag 0), first row (tag 1), last row (tag 1), OP_COL (tag 0), first column (tag 1), last column (tag 1), OP_WR (tag 0). `out_is_data`=1 marks data and 0 marks a command.
- R3: Each row emits exactly (last column − first column + 1) × 2 data bytes.
- R4: One line is emitted for every row from the first row through the last row inclusive. `busy` then returns to 0.
- R5: Byte k of line j is read from `rd_addr` = base + j × stride + k, modulo 2^AW. The byte is forwarded unchanged as `out_byte`. The stride does not depend on the line length.
- R6: `out_frame_end` is 1 on the OP_WR byte of the preamble and on the last byte of each line, and 0 on every other byte.
- R7: With `wire4_en`=1, `dc_pin` is 0 on command bytes and 1 on data bytes, and it stays 1 throughout the pixel lines. With `wire4_en`=0, `dc_pin` stays 0.
- R8: A `start` whose first column exceeds its last column, whose first row exceeds its last row, or whose line exceeds MAX_LINE (128) bytes raises `err` for one cycle, in the cycle after `start`. No byte is emitted.
- R9: `done` pulses for one cycle, in the cycle after the last byte of the last line is accepted, and at no other time.
- R10: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_byte`, `out_is_data` and `out_frame_end` hold their values.
- R11: `start` is ignored while `busy`=1. It raises no `err`, and it does not change the stream in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a window when idle |
| wire4_en | input | 1 | Drive the data/command pin |
| col_first | input | 8 | First column address |
| col_last | input | 8 | Last column address |
| row_first | input | 8 | First row address |
| row_last | input | 8 | Last row address |
| src_base | input | AW | Source address of the first line |
| src_stride | input | AW | Source address step between lines |
| rd_addr | output | AW | Byte source address |
| rd_data | input | 8 | Byte source data, combinational on rd_addr |
| out_valid | output | 1 | Byte available |
| out_ready | input | 1 | Downstream accepts the byte |
| out_byte | output | 8 | Byte value |
| out_is_data | output | 1 | 1 = data, 0 = command |
| out_frame_end | output | 1 | Last byte of a frame |
| dc_pin | output | 1 | Data/command pin for four-wire mode |
| busy | output | 1 | Window in progress |
| done | output | 1 | Window complete pulse |
| err | output | 1 | Refused window pulse |

## Verification
The hardest situation to reach from the ports is a stall on the very byte where the sequencer changes context. That happens on the OP_WR byte that closes the preamble, and on a line's final byte where the row and source base advance. The same applies to the final byte, whose acceptance must produce `done` exactly one cycle later. The bench withholds `out_ready` at random on about a third of cycles over many random windows, so stalls land on these boundary bytes repeatedly. Directed windows add the 128-byte limit, the 130-byte refusal, a one-column line, and rows ending at 255.

// File: rtl/wsq_pkg.sv
package wsq_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_PRE = 2'd1, ST_LINE = 2'd2} wsq_state_e;

  localparam int LEN_W = 10;
  localparam logic [2:0] PRE_LAST = 3'd6;

  // bytes per line: two per column address, inclusive span
  function automatic logic [LEN_W-1:0] line_bytes(input logic [7:0] lo, input logic [7:0] hi);
    logic [LEN_W-1:0] span;
    span = {2'b00, hi} - {2'b00, lo} + 10'd1;
    return {span[LEN_W-2:0], 1'b0};
  endfunction

  function automatic logic window_ok(input logic [7:0] c0, input logic [7:0] c1,
                                     input logic [7:0] r0, input logic [7:0] r1,
                                     input int max_line);
    return (c0 <= c1) && (r0 <= r1) && (int'(line_bytes(c0, c1)) <= max_line);
  endfunction
endpackage

// File: rtl/wsq_preamble.sv
module wsq_preamble #(
  parameter logic [7:0] OP_ROW = 8'h75,
  parameter logic [7:0] OP_COL = 8'h15,
  parameter logic [7:0] OP_WR  = 8'h5C
) (
  input  logic [2:0] step,
  input  logic [7:0] c0,
  input  logic [7:0] c1,
  input  logic [7:0] r0,
  input  logic [7:0] r1,
  output logic [7:0] pbyte,
  output logic       p_is_data,
  output logic       p_end
);
  always_comb begin
    p_is_data = 1'b1;
    unique case (step)
      3'd0: begin pbyte = OP_ROW; p_is_data = 1'b0; end
      3'd1: pbyte = r0;
      3'd2: pbyte = r1;
      3'd3: begin pbyte = OP_COL; p_is_data = 1'b0; end
      3'd4: pbyte = c0;
      3'd5: pbyte = c1;
      default: begin pbyte = OP_WR; p_is_data = 1'b0; end
    endcase
  end
  assign p_end = (step == wsq_pkg::PRE_LAST);
endmodule

// File: rtl/wsq_line_walker.sv
module wsq_line_walker #(
  parameter int AW       = 16,
  parameter int MAX_LINE = 128
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic                     adv,
  input  logic [7:0]               row_first,
  input  logic [7:0]               row_last,
  input  logic [wsq_pkg::LEN_W-1:0] len,
  input  logic [AW-1:0]            base,
  input  logic [AW-1:0]            stride,
  output logic [AW-1:0]            rd_addr,
  output logic                     line_end,
  output logic                     last_row
);
  import wsq_pkg::*;
  localparam int IDX_W = $clog2(MAX_LINE);

  logic [IDX_W-1:0] idx;
  logic [7:0]       row, row_end_q;
  logic [LEN_W-1:0] len_q;
  logic [AW-1:0]    stride_q, line_base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0; row <= '0; row_end_q <= '0; len_q <= '0;
      stride_q <= '0; line_base <= '0;
    end else if (load) begin
      idx <= '0; row <= row_first; row_end_q <= row_last; len_q <= len;
      stride_q <= stride; line_base <= base;
    end else if (adv) begin
      if (line_end) begin
        idx       <= '0;
        row       <= row + 8'd1;
        line_base <= line_base + stride_q;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  assign line_end = ({{(LEN_W-IDX_W){1'b0}}, idx} == len_q - 10'd1);
  assign last_row = (row == row_end_q);
  assign rd_addr  = line_base + {{(AW-IDX_W){1'b0}}, idx};

  // R5
  base_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && line_end && !load) |=> (rd_addr == $past(line_base) + $past(stride_q)));
endmodule

// File: rtl/wsq_ctrl.sv
module wsq_ctrl #(
  parameter int MAX_LINE = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [7:0]          col_first,
  input  logic [7:0]          col_last,
  input  logic [7:0]          row_first,
  input  logic [7:0]          row_last,
  input  logic                hs,
  input  logic                line_end,
  input  logic                last_row,
  output wsq_pkg::wsq_state_e state,
  output logic [2:0]          step,
  output logic [7:0]          c0_q,
  output logic [7:0]          c1_q,
  output logic [7:0]          r0_q,
  output logic [7:0]          r1_q,
  output logic                load,
  output logic                err,
  output logic                done
);
  import wsq_pkg::*;

  logic idle, ok;
  assign idle = (state == ST_IDLE);
  assign ok   = window_ok(col_first, col_last, row_first, row_last, MAX_LINE);
  assign load = start && idle && ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; step <= '0; err <= 1'b0; done <= 1'b0;
      c0_q <= '0; c1_q <= '0; r0_q <= '0; r1_q <= '0;
    end else begin
      err  <= start && idle && !ok;
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (load) begin
          state <= ST_PRE; step <= '0;
          c0_q <= col_first; c1_q <= col_last; r0_q <= row_first; r1_q <= row_last;
        end
        ST_PRE: if (hs) begin
          if (step == PRE_LAST) begin
            state <= ST_LINE; step <= '0;
          end else begin
            step <= step + 3'd1;
          end
        end
        ST_LINE: if (hs && line_end && last_row) begin
          state <= ST_IDLE; done <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && start) |=> ($stable(c0_q) && $stable(c1_q) && $stable(r0_q) && $stable(r1_q) && !err));
endmodule

// File: rtl/wire_window_seq.sv
module wire_window_seq #(
  parameter int         AW       = 16,
  parameter int         MAX_LINE = 128,
  parameter logic [7:0] OP_ROW   = 8'h75,
  parameter logic [7:0] OP_COL   = 8'h15,
  parameter logic [7:0] OP_WR    = 8'h5C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wire4_en,
  input  logic [7:0]    col_first,
  input  logic [7:0]    col_last,
  input  logic [7:0]    row_first,
  input  logic [7:0]    row_last,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] src_stride,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_byte,
  output logic          out_is_data,
  output logic          out_frame_end,
  output logic          dc_pin,
  output logic          busy,
  output logic          done,
  output logic          err
);
  import wsq_pkg::*;

  wsq_state_e state;
  logic [2:0] step;
  logic [7:0] c0_q, c1_q, r0_q, r1_q, pre_byte;
  logic       load, hs, adv, line_end, last_row, pre_is_data, pre_end;

  assign hs  = out_valid && out_ready;
  assign adv = hs && (state == ST_LINE);

  wsq_ctrl #(.MAX_LINE(MAX_LINE)) u_ctrl (
    .clk, .rst_n, .start, .col_first, .col_last, .row_first, .row_last,
    .hs, .line_end, .last_row, .state, .step, .c0_q, .c1_q, .r0_q, .r1_q,
    .load, .err, .done);

  wsq_preamble #(.OP_ROW(OP_ROW), .OP_COL(OP_COL), .OP_WR(OP_WR)) u_pre (
    .step, .c0(c0_q), .c1(c1_q), .r0(r0_q), .r1(r1_q),
    .pbyte(pre_byte), .p_is_data(pre_is_data), .p_end(pre_end));

  wsq_line_walker #(.AW(AW), .MAX_LINE(MAX_LINE)) u_walk (
    .clk, .rst_n, .load, .adv, .row_first, .row_last,
    .len(line_bytes(col_first, col_last)), .base(src_base), .stride(src_stride),
    .rd_addr, .line_end, .last_row);

  always_comb begin
    out_byte      = pre_byte;
    out_is_data   = 1'b0;
    out_frame_end = 1'b0;
    unique case (state)
      ST_PRE:  begin out_is_data = pre_is_data; out_frame_end = pre_end; end
      ST_LINE: begin out_byte = rd_data; out_is_data = 1'b1; out_frame_end = line_end; end
      default: ;
    endcase
  end

  assign out_valid = (state != ST_IDLE);
  assign busy      = out_valid;
  assign dc_pin    = wire4_en && out_is_data;

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_is_data) && $stable(out_frame_end)));
  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !out_valid);
  // R9
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(hs && out_frame_end && out_is_data));
  // R2
  preamble_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (out_byte == OP_ROW && !out_is_data));
  // R7
  line_dc_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !out_frame_end && wire4_en) |=> dc_pin);
endmodule

// File: tb/sim_wire_window_seq.sv
module sim_wire_window_seq;
  localparam int CLK_P = 10;
  localparam int AW = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, wire4_en = 1'b0, out_ready = 1'b1;
  logic [7:0] col_first = '0, col_last = '0, row_first = '0, row_last = '0;
  logic [AW-1:0] src_base = '0, src_stride = '0, rd_addr;
  logic [7:0] rd_data, out_byte;
  logic out_valid, out_is_data, out_frame_end, dc_pin, busy, done, err;

  wire_window_seq u0 (.*);

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction
  assign rd_data = mem_byte(rd_addr);

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0]    eb [0:1023];
  logic          ed [0:1023];
  logic          ef [0:1023];
  logic [AW-1:0] ea [0:1023];
  int en = 0, rx = 0;
  bit final_pend = 0, hold_pend = 0, mon_on = 0;
  logic [7:0] held_b;
  logic held_d, held_f;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b, input logic d, input logic f, input logic [AW-1:0] a);
    eb[en] = b; ed[en] = d; ef[en] = f; ea[en] = a; en++;
  endtask

  task automatic build(input logic [7:0] c0, input logic [7:0] c1, input logic [7:0] r0,
                       input logic [7:0] r1, input logic [AW-1:0] base, input logic [AW-1:0] stride);
    int len;
    en = 0;
    len = (int'(c1) - int'(c0) + 1) * 2;
    push(8'h75, 0, 0, '0); push(r0, 1, 0, '0); push(r1, 1, 0, '0);
    push(8'h15, 0, 0, '0); push(c0, 1, 0, '0); push(c1, 1, 0, '0);
    push(8'h5C, 0, 1, '0);
    for (int j = 0; j <= int'(r1) - int'(r0); j++)
      for (int k = 0; k < len; k++) begin
        logic [AW-1:0] a;
        a = base + AW'(j) * stride + AW'(k);
        push(mem_byte(a), 1, (k == len - 1), a);
      end
  endtask

  always @(negedge clk) if (mon_on) begin
    if (final_pend) begin
      check(done === 1'b1, "R9", "done after last byte", done, 1);
      final_pend = 0;
    end else if (done) check(0, "R9", "spurious done", done, 0);
    if (hold_pend) begin
      check(out_valid && out_byte == held_b && out_is_data == held_d && out_frame_end == held_f,
            "R10", "stalled byte held", out_byte, held_b);
      hold_pend = 0;
    end
    out_ready = ($urandom % 3) != 0;
    if (out_valid) begin
      if (rx >= en) check(0, "R4", "extra byte", rx, en);
      else if (out_ready) begin
        check(out_byte == eb[rx], rx < 7 ? "R2" : "R3", "byte", out_byte, eb[rx]);
        check(out_is_data == ed[rx], "R2", "tag", out_is_data, ed[rx]);
        check(out_frame_end == ef[rx], "R6", "frame end", out_frame_end, ef[rx]);
        check(dc_pin == (wire4_en & ed[rx]), "R7", "dc pin", dc_pin, wire4_en & ed[rx]);
        if (rx >= 7) check(rd_addr == ea[rx], "R5", "source address", rd_addr, ea[rx]);
        rx++;
        if (rx == en) final_pend = 1;
      end else begin
        hold_pend = 1; held_b = out_byte; held_d = out_is_data; held_f = out_frame_end;
      end
    end
  end

  task automatic run_window(input logic [7:0] c0, input logic [7:0] c1, input logic [7:0] r0,
                            input logic [7:0] r1, input logic [AW-1:0] base,
                            input logic [AW-1:0] stride, input bit w4, input bit poke);
    int guard;
    build(c0, c1, r0, r1, base, stride);
    rx = 0;
    @(negedge clk);
    wire4_en = w4; col_first = c0; col_last = c1; row_first = r0; row_last = r1;
    src_base = base; src_stride = stride; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      col_first = 8'd9; col_last = 8'd2; start = 1'b1;
      @(negedge clk); start = 1'b0;
      check(err == 1'b0, "R11", "start while busy raised err", err, 0);
    end
    guard = 0;
    while ((rx < en || final_pend) && guard < 5000) begin @(negedge clk); guard++; end
    @(negedge clk);
    check(rx == en, "R4", "byte count", rx, en);
    check(busy == 1'b0, "R4", "busy after window", busy, 0);
  endtask

  task automatic run_bad(input logic [7:0] c0, input logic [7:0] c1, input logic [7:0] r0,
                         input logic [7:0] r1);
    en = 0; rx = 0;
    @(negedge clk);
    col_first = c0; col_last = c1; row_first = r0; row_last = r1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(err == 1'b1, "R8", "err pulse", err, 1);
    check(out_valid == 1'b0 && busy == 1'b0, "R8", "no output on refusal", out_valid, 0);
    @(negedge clk);
    check(err == 1'b0, "R8", "err single cycle", err, 0);
    repeat (4) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R8", "stays silent", out_valid, 0);
    end
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    check(!out_valid && !busy && !done && !err && !dc_pin, "R1", "reset state",
          {out_valid, busy, done, err, dc_pin}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !busy && !done && !err && !dc_pin, "R1", "idle after reset",
          {out_valid, busy, done, err, dc_pin}, 0);
    mon_on = 1;
    // directed corners: 128-byte line, one column, top rows, right edge
    run_window(8'd10, 8'd73, 8'd3, 8'd3, 16'h1234, 16'd200, 1'b1, 1'b0);
    run_window(8'd5, 8'd5, 8'd7, 8'd7, 16'hFFFE, 16'd3, 1'b0, 1'b0);
    run_window(8'd250, 8'd255, 8'd254, 8'd255, 16'h0100, 16'd1, 1'b1, 1'b1);
    run_window(8'd0, 8'd2, 8'd0, 8'd3, 16'hFFF0, 16'd7, 1'b0, 1'b1);
    run_bad(8'd20, 8'd19, 8'd0, 8'd0);
    run_bad(8'd0, 8'd1, 8'd5, 8'd4);
    run_bad(8'd0, 8'd64, 8'd0, 8'd0);
    for (int n = 0; n < 14; n++) begin
      logic [7:0] c0, r0;
      c0 = 8'($urandom % 60);
      r0 = 8'($urandom % 200);
      run_window(c0, c0 + 8'($urandom % 20), r0, r0 + 8'($urandom % 4),
                 16'($urandom), 16'($urandom % 300 + 1), 1'($urandom % 2), 1'(n % 3 == 0));
    end
    mon_on = 0;
    finish_run();
  end
endmodule